// File: doc/BRIEF.md
# Bus-Master Burst Sequencer with Idle-Free Chaining

This block is the initiator side of a simplified PCI-style shared bus. Two internal clients, an interrupt-posting client (index 0) and a host-service client (index 1), each hold a request level together with an address, a direction, a burst length of two or three dwords and a write seed. The block arbitrates between them, runs the address phase and the data phases, counts the dwords the target accepts, and returns a one-clock completion pulse to the client that was served. Read data is handed back one dword per clock.

Between two transactions the bus normally shows one or more idle clocks, with the cycle strobe and the master-ready strobe both released. The block skips that idle clock and places the next address phase on the clock right after the final data phase when three conditions hold together. The grant is still present. The next transaction comes from the other client. Both addresses fall inside one target window, given by a base and a mask. A target that never claims the cycle, or that signals stop, ends the transaction early and always leaves an idle clock behind it.

Top module: `pcim_b2b_seq`

## Requirements
- R1: While reset is high and on the first clock after it, the bus is idle: `bus_cyc_n` = 1, `bus_mrdy_n` = 1, `bus_aoe` = 0, `bus_cmd_n` = 4'b1111, and `src_done` = 0.
- R2: A transaction opens with exactly one address phase (`bus_cyc_n` = 0, `bus_mrdy_n` = 1) that carries the client address on `bus_aout` and command 4'b0111 for a write or 4'b0110 for a read on `bus_cmd_n`. In each data phase after it, `bus_mrdy_n` = 0, `bus_cmd_n` = 4'b0000, and for writes `bus_aout` = write seed + dword index (starting at 0).
- R3: The burst length is 3 dwords when the client's `src_len3` bit is 1 and 2 dwords otherwise. `bus_cyc_n` is high only in the final data phase. A dword counts only on a clock where `bus_tack_n` = 0 and the target has claimed the cycle, so wait states hold `bus_mrdy_n` low.
- R4: When the final data phase completes with `bus_grant_n` = 0, the other client requesting, and both addresses inside the window ((addr & `win_mask`) == (`win_base` & `win_mask`)), the next address phase is on the very next clock with no idle clock.
- R5: Two consecutive transactions from the same client are always separated by at least one idle clock.
- R6: If either the finished or the next address lies outside the window, at least one idle clock separates the transactions. When the other client is the only one waiting and grant is held, there is exactly one.
- R7: No address phase appears on a clock whose preceding clock had `bus_grant_n` = 1. A grant that is missing at the final data phase stops chaining, and no new transaction starts until the grant returns.
- R8: When both clients request from idle, service alternates, starting with the client not served last. After reset, client 0 is preferred.
- R9: A stop (`bus_tstop_n` = 0 on a claimed data phase) ends the transaction at that clock. The next clock is idle, and the completion reports `src_full` = 0.
- R10: If `bus_tsel_n` stays high for 5 data clocks after the address phase, the transaction is abandoned after the fifth one. The bus goes idle, no dword counts, and `src_full` = 0.
- R11: Every transaction produces exactly one one-clock `src_done` pulse on its own client's bit, on the clock after its last data phase. `src_full` = 1 means all dwords were accepted.
- R12: Each dword accepted during a read appears on `rd_data` with `rd_valid` = 1 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 2 | Request level per client, held until its done pulse |
| src_addr | input | 2x32 | Target address per client |
| src_wr | input | 2 | 1 = write, 0 = read, per client |
| src_len3 | input | 2 | 1 = three-dword burst, 0 = two-dword burst |
| src_wdata | input | 2x32 | Write seed per client |
| src_done | output | 2 | One-clock completion pulse per client |
| src_full | output | 1 | Valid with `src_done`: all dwords accepted |
| rd_valid | output | 1 | Read dword valid |
| rd_data | output | 32 | Read dword |
| win_base | input | 32 | Target window base |
| win_mask | input | 32 | Target window mask |
| bus_grant_n | input | 1 | Bus grant, active low |
| bus_cyc_n | output | 1 | Cycle strobe, active low |
| bus_mrdy_n | output | 1 | Master ready, active low |
| bus_tack_n | input | 1 | Target data accept, active low |
| bus_tstop_n | input | 1 | Target stop, active low |
| bus_tsel_n | input | 1 | Target claim, active low |
| bus_aout | output | 32 | Address / write data driven by the master |
| bus_aoe | output | 1 | Enable for `bus_aout` |
| bus_ain | input | 32 | Read data from the bus |
| bus_cmd_n | output | 4 | Command in address phase, byte enables in data phases |

## Verification
The closing data phase of one transaction and the decision to start the next one fall on the same clock edge. On that edge the block samples the target's accept, the grant, the other client's request and both window matches, and the finishing client's done pulse coincides with the new address phase. The bench sets this up by raising both clients at once, or by raising the second client during the first burst. It then varies one input at a time at that edge: the grant, the window, the stop, and the source identity. The result is judged by the count of idle clocks the monitor records between consecutive address phases: zero for a chained start, and one or more for every other case.

// File: rtl/pcim_b2b_pkg.sv
package pcim_b2b_pkg;

    localparam int ADW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] BE_ALL_N   = 4'b0000;
    localparam logic [3:0] CMD_NONE   = 4'b1111;

    typedef struct packed {
        logic [ADW-1:0] addr;
        logic [ADW-1:0] wdata;
        logic           wr;
        logic           len3;
    } xact_t;

    function automatic logic in_win(input logic [ADW-1:0] a,
                                    input logic [ADW-1:0] base,
                                    input logic [ADW-1:0] mask);
        return (a & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/b2b_rr_arb.sv
module b2b_rr_arb (
    input  logic [1:0] req,
    input  logic       last,
    output logic       pick,
    output logic       any
);
    always_comb begin
        any  = |req;
        pick = (&req) ? ~last : req[1];
    end
endmodule

// File: rtl/b2b_win_chk.sv
module b2b_win_chk
    import pcim_b2b_pkg::*;
#(
    parameter int NCMP = 2
) (
    input  logic [NCMP-1:0][ADW-1:0] addr,
    input  logic [ADW-1:0]           base,
    input  logic [ADW-1:0]           mask,
    output logic                     all_in
);
    logic [NCMP-1:0] hit;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign hit[g] = in_win(addr[g], base, mask);
    end

    assign all_in = &hit;
endmodule

// File: rtl/pcim_b2b_seq.sv
module pcim_b2b_seq
    import pcim_b2b_pkg::*;
#(
    parameter int DEVSEL_WAIT = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          src_req,
    input  logic [1:0][ADW-1:0] src_addr,
    input  logic [1:0]          src_wr,
    input  logic [1:0]          src_len3,
    input  logic [1:0][ADW-1:0] src_wdata,
    output logic [1:0]          src_done,
    output logic                src_full,
    output logic                rd_valid,
    output logic [ADW-1:0]      rd_data,
    input  logic [ADW-1:0]      win_base,
    input  logic [ADW-1:0]      win_mask,
    input  logic                bus_grant_n,
    output logic                bus_cyc_n,
    output logic                bus_mrdy_n,
    input  logic                bus_tack_n,
    input  logic                bus_tstop_n,
    input  logic                bus_tsel_n,
    output logic [ADW-1:0]      bus_aout,
    output logic                bus_aoe,
    input  logic [ADW-1:0]      bus_ain,
    output logic [3:0]          bus_cmd_n
);
    localparam int WCW = $clog2(DEVSEL_WAIT + 1);
    localparam logic [WCW-1:0] WAIT_LAST = WCW'(DEVSEL_WAIT - 1);

    bus_st_e        st_q;
    logic           cur_q, last_q;
    xact_t          xa_q;
    logic [1:0]     cnt_q;
    logic           dsel_q;
    logic [WCW-1:0] wcnt_q;
    logic [1:0]     done_q;
    logic           full_q, rdv_q;
    logic [ADW-1:0] rdd_q;

    xact_t req_x [2];
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            req_x[i] = '{addr: src_addr[i], wdata: src_wdata[i],
                         wr: src_wr[i], len3: src_len3[i]};
        end
    end

    // Arbitration: a client whose done pulse is showing is not eligible
    logic [1:0] eff_req;
    logic       pick, any;
    assign eff_req = src_req & ~done_q;

    b2b_rr_arb u_arb (
        .req  (eff_req),
        .last (last_q),
        .pick (pick),
        .any  (any)
    );

    // Window match of the running and the candidate follow-on address
    logic                oth;
    xact_t               oth_x;
    logic [1:0][ADW-1:0] cmp_addr;
    logic                win_ok;
    assign oth      = ~cur_q;
    assign oth_x    = req_x[oth];
    assign cmp_addr = {oth_x.addr, xa_q.addr};

    b2b_win_chk #(.NCMP(2)) u_win (
        .addr   (cmp_addr),
        .base   (win_base),
        .mask   (win_mask),
        .all_in (win_ok)
    );

    // Data-phase decode
    logic in_data, last_ph, grant, dsel, tack, tstop, abort, end_any, full_now, chain;
    always_comb begin
        in_data  = (st_q == ST_DATA);
        last_ph  = in_data && (cnt_q == (xa_q.len3 ? 2'd2 : 2'd1));
        grant    = !bus_grant_n;
        dsel     = dsel_q || !bus_tsel_n;
        tack     = in_data && dsel && !bus_tack_n;
        tstop    = in_data && dsel && !bus_tstop_n;
        abort    = in_data && !dsel && (wcnt_q == WAIT_LAST);
        end_any  = abort || tstop || (tack && last_ph);
        full_now = tack && last_ph;
        chain    = end_any && full_now && !tstop && grant && src_req[oth] && win_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= 1'b0;
            last_q <= 1'b1;
            xa_q   <= '0;
            cnt_q  <= '0;
            dsel_q <= 1'b0;
            wcnt_q <= '0;
            done_q <= '0;
            full_q <= 1'b0;
            rdv_q  <= 1'b0;
            rdd_q  <= '0;
        end else begin
            done_q <= '0;
            rdv_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (grant && any) begin
                        st_q   <= ST_ADDR;
                        cur_q  <= pick;
                        last_q <= pick;
                        xa_q   <= req_x[pick];
                    end
                end
                ST_ADDR: begin
                    st_q   <= ST_DATA;
                    cnt_q  <= '0;
                    dsel_q <= 1'b0;
                    wcnt_q <= '0;
                end
                ST_DATA: begin
                    dsel_q <= dsel;
                    if (!dsel) wcnt_q <= wcnt_q + 1'b1;
                    if (tack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (!xa_q.wr) begin
                            rdv_q <= 1'b1;
                            rdd_q <= bus_ain;
                        end
                    end
                    if (end_any) begin
                        done_q[cur_q] <= 1'b1;
                        full_q        <= full_now;
                        if (chain) begin
                            st_q   <= ST_ADDR;
                            cur_q  <= oth;
                            last_q <= oth;
                            xa_q   <= oth_x;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_cyc_n  = !((st_q == ST_ADDR) || (in_data && !last_ph));
        bus_mrdy_n = !in_data;
        bus_aoe    = (st_q == ST_ADDR) || (in_data && xa_q.wr);
        bus_aout   = (st_q == ST_ADDR) ? xa_q.addr : (xa_q.wdata + ADW'(cnt_q));
        if (st_q == ST_ADDR)  bus_cmd_n = xa_q.wr ? CMD_MEM_WR : CMD_MEM_RD;
        else if (in_data)     bus_cmd_n = BE_ALL_N;
        else                  bus_cmd_n = CMD_NONE;
    end

    assign src_done = done_q;
    assign src_full = full_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;
endmodule

// File: rtl/pcim_b2b_seq_chk.sv
module pcim_b2b_seq_chk
    import pcim_b2b_pkg::*;
#(
    parameter int DEVSEL_WAIT = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_grant_n,
    input logic           bus_cyc_n,
    input logic           bus_mrdy_n,
    input logic           bus_tack_n,
    input logic           bus_tstop_n,
    input logic           bus_tsel_n,
    input logic [ADW-1:0] bus_aout,
    input logic [1:0]     src_done,
    input logic           src_full,
    input logic [ADW-1:0] win_base,
    input logic [ADW-1:0] win_mask
);
    localparam int DCW = $clog2(DEVSEL_WAIT + 2);

    logic           addr_ph;
    logic [DCW-1:0] dly_q;
    logic           seen_q;
    assign addr_ph = !bus_cyc_n && bus_mrdy_n;

    always_ff @(posedge clk) begin
        if (rst || addr_ph) begin
            dly_q  <= '0;
            seen_q <= 1'b0;
        end else if (!bus_mrdy_n) begin
            if (!bus_tsel_n) seen_q <= 1'b1;
            if (dly_q != DCW'(DEVSEL_WAIT + 1)) dly_q <= dly_q + 1'b1;
        end
    end

    // R7
    grant_gate_chk: assert property (@(posedge clk) disable iff (rst)
        bus_grant_n |=> !(!bus_cyc_n && bus_mrdy_n));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_mrdy_n && !bus_tstop_n && !bus_tsel_n) |=> (bus_cyc_n && bus_mrdy_n));

    // R4
    chain_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_ph && $past(!bus_mrdy_n)) |->
            (src_full && $countones(src_done) == 1 && in_win(bus_aout, win_base, win_mask)));

    // R11
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_done));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_mrdy_n && bus_tack_n && bus_tstop_n && !bus_tsel_n) |=> !bus_mrdy_n);

    // R10
    claim_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_mrdy_n && !seen_q && bus_tsel_n) |-> (dly_q < DCW'(DEVSEL_WAIT)));
endmodule

bind pcim_b2b_seq pcim_b2b_seq_chk #(.DEVSEL_WAIT(DEVSEL_WAIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_grant_n (bus_grant_n),
    .bus_cyc_n   (bus_cyc_n),
    .bus_mrdy_n  (bus_mrdy_n),
    .bus_tack_n  (bus_tack_n),
    .bus_tstop_n (bus_tstop_n),
    .bus_tsel_n  (bus_tsel_n),
    .bus_aout    (bus_aout),
    .src_done    (src_done),
    .src_full    (src_full),
    .win_base    (win_base),
    .win_mask    (win_mask)
);

// File: tb/pcim_b2b_seq_bench.sv
`timescale 1ns/100ps
module pcim_b2b_seq_bench;
    import pcim_b2b_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          src_req = '0;
    logic [1:0][ADW-1:0] src_addr = '0;
    logic [1:0]          src_wr = '0;
    logic [1:0]          src_len3 = '0;
    logic [1:0][ADW-1:0] src_wdata = '0;
    logic [1:0]          src_done;
    logic                src_full;
    logic                rd_valid;
    logic [ADW-1:0]      rd_data;
    logic [ADW-1:0]      win_base = 32'h1000_0000;
    logic [ADW-1:0]      win_mask = 32'hFFFF_0000;
    logic                bus_grant_n = 1'b0;
    logic                bus_cyc_n, bus_mrdy_n, bus_aoe;
    logic                bus_tack_n = 1'b0;
    logic                bus_tstop_n = 1'b1;
    logic                bus_tsel_n = 1'b0;
    logic [ADW-1:0]      bus_aout;
    logic [ADW-1:0]      bus_ain = 32'h5EED_0001;
    logic [3:0]          bus_cmd_n;

    always #2.5 clk = ~clk;

    pcim_b2b_seq u_pcim_b2b_seq (
        .clk(clk), .rst(rst), .src_req(src_req), .src_addr(src_addr),
        .src_wr(src_wr), .src_len3(src_len3), .src_wdata(src_wdata),
        .src_done(src_done), .src_full(src_full), .rd_valid(rd_valid),
        .rd_data(rd_data), .win_base(win_base), .win_mask(win_mask),
        .bus_grant_n(bus_grant_n), .bus_cyc_n(bus_cyc_n), .bus_mrdy_n(bus_mrdy_n),
        .bus_tack_n(bus_tack_n), .bus_tstop_n(bus_tstop_n), .bus_tsel_n(bus_tsel_n),
        .bus_aout(bus_aout), .bus_aoe(bus_aoe), .bus_ain(bus_ain), .bus_cmd_n(bus_cmd_n)
    );

    int checks = 0, fails = 0;
    int addr_cnt, idle_run, mrdy_cnt, cyc_cnt, xfer_cnt, done_cnt, rd_cnt;
    logic [ADW-1:0] addr_log [16];
    logic [3:0]     cmd_log  [16];
    int             gap_log  [16];
    logic [ADW-1:0] wd_log   [16];
    logic           dsrc_log [16];
    logic           dfull_log[16];
    logic [ADW-1:0] rd_last;
    logic [1:0]     keep = '0;

    // Bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (!bus_cyc_n && bus_mrdy_n) begin
                addr_log[addr_cnt % 16] = bus_aout;
                cmd_log[addr_cnt % 16]  = bus_cmd_n;
                gap_log[addr_cnt % 16]  = idle_run;
                addr_cnt++;
                idle_run = 0;
            end else if (bus_cyc_n && bus_mrdy_n) begin
                idle_run++;
            end
            if (!bus_cyc_n) cyc_cnt++;
            if (!bus_mrdy_n) mrdy_cnt++;
            if (!bus_mrdy_n && !bus_tack_n && !bus_tsel_n) begin
                wd_log[xfer_cnt % 16] = bus_aout;
                xfer_cnt++;
            end
            if (src_done != 2'b00) begin
                dsrc_log[done_cnt % 16]  = src_done[1];
                dfull_log[done_cnt % 16] = src_full;
                done_cnt++;
            end
            if (rd_valid) begin
                rd_cnt++;
                rd_last = rd_data;
            end
        end
    end

    // Client model: drop the request once its done pulse shows
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < 2; i++)
            if (src_done[i] && !keep[i]) src_req[i] = 1'b0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic mon_clear();
        addr_cnt = 0; idle_run = 0; mrdy_cnt = 0; cyc_cnt = 0;
        xfer_cnt = 0; done_cnt = 0; rd_cnt = 0; rd_last = '0;
    endtask

    task automatic set_src(input int i, input logic [31:0] a, input logic wr,
                           input logic l3, input logic [31:0] wd);
        src_addr[i] = a; src_wr[i] = wr; src_len3[i] = l3; src_wdata[i] = wd;
    endtask

    task automatic wait_done(input int n);
        int g = 0;
        while (done_cnt < n && g < 500) begin @(posedge clk); g++; end
        #1;
    endtask

    task automatic wait_addr(input int n);
        int g = 0;
        while (addr_cnt < n && g < 500) begin @(posedge clk); g++; end
        #1;
    endtask

    task automatic wait_xfer(input int n);
        int g = 0;
        while (xfer_cnt < n && g < 500) begin @(posedge clk); g++; end
        #1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 cyc_n in reset", bus_cyc_n, 1);
        chk("R1 mrdy_n in reset", bus_mrdy_n, 1);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk("R1 cyc_n after reset", bus_cyc_n, 1);
        chk("R1 mrdy_n after reset", bus_mrdy_n, 1);
        chk("R1 aoe after reset", bus_aoe, 0);
        chk("R1 cmd after reset", bus_cmd_n, 4'b1111);
        chk("R1 done after reset", src_done, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_single_write();
        mon_clear();
        set_src(0, 32'h1000_0010, 1'b1, 1'b0, 32'h0000_00A0);
        src_req[0] = 1'b1;
        wait_done(1);
        settle(3);
        chk("R2 one address phase", addr_cnt, 1);
        chk("R2 address on bus", addr_log[0], 32'h1000_0010);
        chk("R2 write command", cmd_log[0], 4'b0111);
        chk("R2 write dword 0", wd_log[0], 32'hA0);
        chk("R2 write dword 1", wd_log[1], 32'hA1);
        chk("R3 two-dword burst", xfer_cnt, 2);
        chk("R3 cyc_n high only in final phase", cyc_cnt, 2);
        chk("R11 done from client 0", dsrc_log[0], 0);
        chk("R11 full completion", dfull_log[0], 1);
        chk("R11 single done pulse", done_cnt, 1);
    endtask

    task automatic t_chain();
        mon_clear();
        set_src(0, 32'h1000_0100, 1'b1, 1'b1, 32'h0000_00B0);
        set_src(1, 32'h1000_0200, 1'b0, 1'b0, 32'h0);
        src_req = 2'b11;
        wait_done(2);
        settle(3);
        chk("R8 client 1 served first", addr_log[0], 32'h1000_0200);
        chk("R2 read command", cmd_log[0], 4'b0110);
        chk("R4 no idle clock before chained start", gap_log[1], 0);
        chk("R4 chained address", addr_log[1], 32'h1000_0100);
        chk("R3 three-dword burst last data", wd_log[4], 32'hB2);
        chk("R11 both full", {dfull_log[0], dfull_log[1]}, 2'b11);
        chk("R11 done order", {dsrc_log[0], dsrc_log[1]}, 2'b10);
        chk("R12 read dword count", rd_cnt, 2);
        chk("R12 read data", rd_last, 32'h5EED_0001);
    endtask

    task automatic t_same_src();
        mon_clear();
        set_src(0, 32'h1000_0300, 1'b1, 1'b0, 32'h0000_00C0);
        keep[0] = 1'b1;
        src_req[0] = 1'b1;
        wait_done(1);
        keep[0] = 1'b0;
        wait_done(2);
        settle(3);
        chk("R5 two transactions", addr_cnt, 2);
        chk_ge("R5 idle between same-client transactions", gap_log[1], 1);
    endtask

    task automatic t_window();
        mon_clear();
        set_src(0, 32'h1000_0400, 1'b1, 1'b0, 32'h0000_00D0);
        set_src(1, 32'h2000_0400, 1'b1, 1'b0, 32'h0000_00E0);
        src_req[0] = 1'b1;
        wait_addr(1);
        src_req[1] = 1'b1;
        wait_done(2);
        settle(3);
        chk("R6 out-of-window follow-on address", addr_log[1], 32'h2000_0400);
        chk("R6 exactly one idle clock", gap_log[1], 1);
    endtask

    task automatic t_grant();
        mon_clear();
        bus_grant_n = 1'b1;
        set_src(0, 32'h1000_0500, 1'b1, 1'b0, 32'h0000_00F0);
        set_src(1, 32'h1000_0600, 1'b1, 1'b0, 32'h0000_0010);
        src_req[0] = 1'b1;
        settle(8);
        chk("R7 no start without grant", addr_cnt, 0);
        bus_grant_n = 1'b0;
        wait_addr(1);
        bus_grant_n = 1'b1;
        src_req[1] = 1'b1;
        settle(8);
        chk("R7 no chaining after grant loss", addr_cnt, 1);
        chk("R7 bus idle without grant", {bus_cyc_n, bus_mrdy_n}, 2'b11);
        bus_grant_n = 1'b0;
        wait_done(2);
        settle(3);
        chk_ge("R7 idle gap while grant absent", gap_log[1], 6);
    endtask

    task automatic t_stop();
        mon_clear();
        set_src(0, 32'h1000_0700, 1'b1, 1'b1, 32'h0000_0020);
        set_src(1, 32'h1000_0800, 1'b1, 1'b0, 32'h0000_0030);
        src_req[0] = 1'b1;
        wait_addr(1);
        src_req[1] = 1'b1;
        wait_xfer(1);
        bus_tstop_n = 1'b0;
        settle(1);
        bus_tstop_n = 1'b1;
        wait_done(2);
        settle(3);
        chk("R9 stopped client", dsrc_log[0], 0);
        chk("R9 stop reports incomplete", dfull_log[0], 0);
        chk("R9 idle clock after stop", gap_log[1], 1);
        chk("R9 data clocks before stop end", mrdy_cnt, 2 + 2);
    endtask

    task automatic t_abort();
        mon_clear();
        bus_tsel_n = 1'b1;
        set_src(1, 32'h1000_0900, 1'b0, 1'b0, 32'h0);
        src_req[1] = 1'b1;
        wait_done(1);
        settle(4);
        bus_tsel_n = 1'b0;
        chk("R10 data clocks before abandon", mrdy_cnt, 5);
        chk("R10 abandoned incomplete", dfull_log[0], 0);
        chk("R10 no dword counted", rd_cnt, 0);
        chk("R10 bus idle afterwards", {bus_cyc_n, bus_mrdy_n}, 2'b11);
        chk("R10 single address phase", addr_cnt, 1);
    endtask

    task automatic t_wait_states();
        mon_clear();
        bus_tack_n = 1'b1;
        set_src(0, 32'h1000_0A00, 1'b1, 1'b0, 32'h0000_0040);
        src_req[0] = 1'b1;
        wait_addr(1);
        settle(3);
        bus_tack_n = 1'b0;
        wait_done(1);
        settle(3);
        chk("R3 dwords with wait states", xfer_cnt, 2);
        chk("R3 mrdy held through waits", mrdy_cnt, 5);
        chk("R3 first dword after waits", wd_log[0], 32'h40);
        chk("R11 full after waits", dfull_log[0], 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        mon_clear();
        settle(3);
        t_reset();
        t_single_write();
        t_chain();
        t_same_src();
        t_window();
        t_grant();
        t_stop();
        t_abort();
        t_wait_states();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule